// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block lets a host read and write PHY management registers over a two-wire MDC/MDIO bus. The host reaches it through a flat register port with an address, a write strobe, write data and combinational read data. Two words are visible. The command word holds the start/busy flag, the direction, a clock-range code, the PHY register number and the PHY address. The data word holds the 16-bit value to send, or the value that came back.

Writing the command word with the start bit set launches one Clause 22 frame. The block divides its system clock down to MDC by a ratio that the clock-range code selects. It shifts out preamble, start, opcode, PHY address, register number and turnaround. It then either drives 16 data bits or releases MDIO and samples 16 bits from the PHY. The busy bit clears by itself when the frame ends, and the host polls it. MDIO is brought out as separate output, output-enable and input pins so that the pad can build the tri-state.

Top module: `mdio_host_master`

## Requirements
- R1: The command word is at byte offset 0x10 and the data word at byte offset 0x14. Command readback is {16'b0, phy[4:0] in 15:11, reg[4:0] in 10:6, 1'b0 in bit 5, range[2:0] in 4:2, dir in bit 1, busy in bit 0}. Any other offset reads 0 and ignores writes.
- R2: Writing the command word with bit 0 = 1 while idle starts a frame, and bit 0 reads 1 from the next cycle. It reads 0 again exactly 64·N cycles after the launch edge, where N is the MDC ratio.
- R3: MDC is low while idle. During a frame it toggles every N/2 system cycles, with the first rising edge N/2 cycles after launch. N is 42, 62, 16, 26, 102 or 124 for range codes 0 to 5, and 124 for codes 6 and 7.
- R4: Frame bit b (0..63) is on MDIO during cycles b·N to (b+1)·N−1 after launch. The bit order is 32 ones, start 01, opcode 10 for a read (bit 1 = 0) or 01 for a write (bit 1 = 1), PHY address MSB first, register number MSB first, turnaround 10 for a write, then 16 data bits MSB first.
- R5: The MDIO output enable is high for the whole of a write frame and for bits 0..45 of a read frame. It is low for bits 46..63 of a read frame and whenever the block is idle.
- R6: A read frame samples MDIO input on the MDC rising edge of bits 48..63, MSB first. The 16-bit result is in the data word by the cycle in which busy reads 0.
- R7: While busy, writes to the command word and to the data word have no effect. The frame in flight, the command fields and the data word are all left unchanged.
- R8: Bits 31:16 of the data word read as zero, whatever value was written to them.
- R9: A write frame sends the data word as it stood at launch. Writing the command word with bit 0 = 0 while idle stores the fields and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable, high when the block drives |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The assertions assume that the host never reprograms the range code in the middle of a frame. The command register makes that impossible, so the code only changes at launch. They also assume that reset is held for at least one clock before the first access.

The stimulus keeps mdio_i at a defined level at all times. It idles at 1 and drives turnaround and read data only in the bit windows where the block has released the line. All of its changes are made at falling system-clock edges, clear of every sampling edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int MII_W     = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 5 + 5 + 2 + MII_W;
  localparam int TA_POS    = FRAME_LEN - MII_W - 2;
  localparam int DATA_POS  = FRAME_LEN - MII_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = 7;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [2:0] range;
    logic       wr;
  } mgmt_cmd_t;

  // Half of the MDC ratio for each clock-range code.
  function automatic logic [DIV_W-1:0] mdc_half_period(input logic [2:0] range);
    case (range)
      3'd0:    mdc_half_period = DIV_W'(21);
      3'd1:    mdc_half_period = DIV_W'(31);
      3'd2:    mdc_half_period = DIV_W'(8);
      3'd3:    mdc_half_period = DIV_W'(13);
      3'd4:    mdc_half_period = DIV_W'(51);
      default: mdc_half_period = DIV_W'(62);
    endcase
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(input mgmt_cmd_t c,
                                                       input logic [MII_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    logic [MII_W-1:0] pay;
    op  = c.wr ? 2'b01 : 2'b10;
    ta  = c.wr ? 2'b10 : 2'b00;
    pay = c.wr ? d : '0;
    build_frame = {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regn, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div
  import mdio_mgmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] range,
  output logic       mdc,
  output logic       rise_evt,
  output logic       fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             term;

  assign half     = mdc_half_period(range);
  assign term     = run && (cnt == half - 1'b1);
  assign rise_evt = term && !mdc;
  assign fall_evt = term && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: MDC settles low whenever no frame runs
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R3: edges are separated by at least one full half period
  a_r3_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt || fall_evt) |=> !(rise_evt || fall_evt));
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             run,
  input  mgmt_cmd_t        cmd,
  input  logic [MII_W-1:0] tx_data,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done_evt,
  output logic [MII_W-1:0] rd_data
);
  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic                 last_bit;
  logic                 in_data;
  logic                 released;

  assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
  assign in_data  = (bit_idx >= IDX_W'(DATA_POS));
  assign released = !cmd.wr && (bit_idx >= IDX_W'(TA_POS));
  assign done_evt = run && fall_evt && last_bit;
  assign mdio_o   = run ? shreg[FRAME_LEN-1] : 1'b1;
  assign mdio_oe  = run && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
      rd_data <= '0;
    end else if (launch) begin
      shreg   <= build_frame(cmd, tx_data);
      bit_idx <= '0;
    end else begin
      if (run && fall_evt && !last_bit) begin
        shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
      if (run && rise_evt && !cmd.wr && in_data)
        rd_data <= {rd_data[MII_W-2:0], mdio_i};
    end
  end

  // R2: a frame ends only after its last bit
  a_r2_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> bit_idx == IDX_W'(FRAME_LEN - 1));
  // R5: line released through turnaround and data of a read
  a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmd.wr && bit_idx >= IDX_W'(TA_POS)) |-> !mdio_oe);
  // R5: a write keeps the line driven
  a_r5_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd.wr) |-> mdio_oe);
endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BUS_W    = 32,
  parameter int CTRL_OFS = 'h10,
  parameter int DATA_OFS = 'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic             reg_we,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int PAD_W = BUS_W - MII_W;

  logic             busy_q;
  mgmt_cmd_t        cmd_q;
  logic [MII_W-1:0] data_q;
  logic             hit_ctrl, hit_data, launch;
  logic             rise_evt, fall_evt, done_evt;
  logic [MII_W-1:0] rd_data;
  wire              unused_wbits = ^{reg_wdata[BUS_W-1:MII_W], reg_wdata[5]};

  assign hit_ctrl = reg_we && (reg_addr == ADDR_W'(CTRL_OFS));
  assign hit_data = reg_we && (reg_addr == ADDR_W'(DATA_OFS));
  assign launch   = hit_ctrl && !busy_q && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (hit_ctrl && !busy_q) begin
        cmd_q.phy   <= reg_wdata[15:11];
        cmd_q.regn  <= reg_wdata[10:6];
        cmd_q.range <= reg_wdata[4:2];
        cmd_q.wr    <= reg_wdata[1];
      end
      if (launch)        busy_q <= 1'b1;
      else if (done_evt) busy_q <= 1'b0;
      if (done_evt && !cmd_q.wr)   data_q <= rd_data;
      else if (hit_data && !busy_q) data_q <= reg_wdata[MII_W-1:0];
    end
  end

  // The frame is built from the fields being written at the launch edge.
  mgmt_cmd_t launch_cmd;
  always_comb begin
    launch_cmd = cmd_q;
    if (launch) begin
      launch_cmd.phy   = reg_wdata[15:11];
      launch_cmd.regn  = reg_wdata[10:6];
      launch_cmd.range = reg_wdata[4:2];
      launch_cmd.wr    = reg_wdata[1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_OFS))
      reg_rdata = {{PAD_W{1'b0}}, cmd_q.phy, cmd_q.regn, 1'b0,
                   cmd_q.range, cmd_q.wr, busy_q};
    else if (reg_addr == ADDR_W'(DATA_OFS))
      reg_rdata = {{PAD_W{1'b0}}, data_q};
  end

  mdio_mdc_div i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .range    (cmd_q.range),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_shift i_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .run      (busy_q),
    .cmd      (launch ? launch_cmd : cmd_q),
    .tx_data  (data_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done_evt (done_evt),
    .rd_data  (rd_data)
  );

  // R2: busy only drops on the frame's completion event
  a_r2_fall_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done_evt));
  // R7: command fields frozen while a frame runs
  a_r7_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cmd_q));
  // R7: data word frozen until completion
  a_r7_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_evt) |=> $stable(data_q));
  // R5: line released whenever idle
  a_r5_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);
endmodule

// File: tb/test_mdio_host_master.sv
module test_mdio_host_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h10;
  localparam logic [7:0] DATA = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = CTRL;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_host_master i_mdio_host_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ratios[8] = '{42, 62, 16, 26, 102, 124, 124, 124};
  bit          m_busy = 0;
  bit          m_wr = 0;
  int          m_k = 0;
  int          m_n = 16;
  logic [15:0] m_ctrl = '0;
  logic [15:0] m_data = '0;
  logic [15:0] phy_val = '0;
  bit          m_bits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_ctrl = '0; m_data = '0;
    end else if (m_busy) begin
      m_k++;
      if (m_k == 64 * m_n) begin
        m_busy = 0;
        if (!m_wr) m_data = phy_val;
      end
    end else if (reg_we) begin
      if (reg_addr == CTRL) begin
        m_ctrl = reg_wdata[15:0] & 16'hFFDE;
        if (reg_wdata[0]) begin
          m_busy = 1; m_k = 0; m_wr = reg_wdata[1];
          m_n = ratios[reg_wdata[4:2]];
          m_bits.delete();
          repeat (32) m_bits.push_back(1'b1);
          m_bits.push_back(1'b0); m_bits.push_back(1'b1);
          m_bits.push_back(!m_wr); m_bits.push_back(m_wr);
          for (int i = 15; i >= 6; i--) m_bits.push_back(reg_wdata[i]);
          m_bits.push_back(m_wr); m_bits.push_back(1'b0);
          for (int i = 15; i >= 0; i--) m_bits.push_back(m_wr ? m_data[i] : 1'b0);
        end
      end else if (reg_addr == DATA) begin
        m_data = reg_wdata[15:0];
      end
    end
  end

  // per-cycle comparison and PHY stimulus, away from the active edge
  int  c_b;
  int  c_mdc;
  bit  c_oe;
  always @(negedge clk) begin
    if (rst_n) begin
      c_b   = m_busy ? m_k / m_n : 0;
      c_mdc = m_busy ? (m_k / (m_n / 2)) % 2 : 0;
      c_oe  = m_busy && (m_wr || c_b < 46);
      check(mdc === c_mdc[0], "R3 mdc level", longint'(mdc), longint'(c_mdc));
      check(mdio_oe === c_oe, "R5 output enable", longint'(mdio_oe), longint'(c_oe));
      if (c_oe)
        check(mdio_o === m_bits[c_b], "R4 frame bit", longint'(mdio_o), longint'(m_bits[c_b]));
      if (reg_addr == CTRL)
        check(reg_rdata[0] === m_busy, "R2 busy flag", longint'(reg_rdata[0]), longint'(m_busy));
      if (m_busy && !m_wr && c_b == 47) mdio_i = 1'b0;
      else if (m_busy && !m_wr && c_b >= 48) mdio_i = phy_val[63 - c_b];
      else mdio_i = 1'b1;
    end
  end

  // ---------------- host access tasks ----------------
  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = CTRL;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
    reg_addr = CTRL;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!m_busy && reg_rdata[0] == 1'b0) break;
    end
    repeat (3) @(posedge clk);
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [2:0] rng, input bit wr, input bit go);
    return {16'h0, phy, rg, 1'b0, rng, wr, go};
  endfunction

  logic [31:0] rd;

  initial begin
    #(CLK_PERIOD * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1, R8 reset state
    host_read(CTRL, rd); check(rd == 32'h0, "R1 ctrl after reset", rd, 0);
    host_read(DATA, rd); check(rd == 32'h0, "R8 data after reset", rd, 0);

    // R1 data word and R8 upper bits zero
    host_write(DATA, 32'hFFFF_A5C3);
    host_read(DATA, rd); check(rd == 32'h0000_A5C3, "R8 data upper zero", rd, 32'hA5C3);

    // R1 unmapped offset
    host_write(8'h18, 32'h1234_5678);
    host_read(8'h18, rd); check(rd == 32'h0, "R1 unmapped read", rd, 0);
    host_read(DATA, rd); check(rd == 32'hA5C3, "R1 unmapped write ignored", rd, 32'hA5C3);

    // R9 fields stored without start
    host_write(CTRL, 32'hFFFF_0000 | cmd_word(5'h0A, 5'h03, 3'd1, 1'b1, 1'b0) | 32'h20);
    repeat (40) @(posedge clk);
    host_read(CTRL, rd);
    check(rd == {16'h0, m_ctrl[15:1], 1'b0}, "R9 store without start", rd, {16'h0, m_ctrl});

    // R4 R9 write frame, fast range
    host_write(DATA, 32'h1234);
    host_write(CTRL, cmd_word(5'h05, 5'h11, 3'd2, 1'b1, 1'b1));
    wait_idle();
    host_read(DATA, rd); check(rd == 32'h1234, "R9 data kept after write frame", rd, 32'h1234);

    // R6 read frame, range 3
    phy_val = 16'hBEEF;
    host_write(CTRL, cmd_word(5'h1F, 5'h00, 3'd3, 1'b0, 1'b1));
    wait_idle();
    host_read(DATA, rd); check(rd == 32'hBEEF, "R6 read data", rd, 32'hBEEF);

    // R7 writes during a read frame are ignored
    phy_val = 16'h8001;
    host_write(CTRL, cmd_word(5'h12, 5'h1E, 3'd0, 1'b0, 1'b1));
    repeat (300) @(posedge clk);
    host_write(CTRL, cmd_word(5'h01, 5'h01, 3'd5, 1'b1, 1'b1));
    host_write(DATA, 32'h5555);
    host_read(CTRL, rd);
    check(rd == {16'h0, 5'h12, 5'h1E, 1'b0, 3'd0, 1'b0, 1'b1}, "R7 ctrl unchanged while busy",
          rd, {16'h0, 5'h12, 5'h1E, 6'b000001});
    wait_idle();
    host_read(DATA, rd); check(rd == 32'h8001, "R7 R6 read result kept", rd, 32'h8001);

    // R7 data write during a write frame ignored, slow range 6
    host_write(DATA, 32'h0F0F);
    host_write(CTRL, cmd_word(5'h03, 5'h04, 3'd6, 1'b1, 1'b1));
    repeat (500) @(posedge clk);
    host_write(DATA, 32'hFFFF);
    wait_idle();
    host_read(DATA, rd); check(rd == 32'h0F0F, "R7 data unchanged", rd, 32'h0F0F);

    // R3 remaining range codes
    phy_val = 16'h6C39;
    host_write(CTRL, cmd_word(5'h07, 5'h09, 3'd1, 1'b0, 1'b1));
    wait_idle();
    host_read(DATA, rd); check(rd == 32'h6C39, "R6 read range 1", rd, 32'h6C39);
    host_write(DATA, 32'hC3A5);
    host_write(CTRL, cmd_word(5'h10, 5'h15, 3'd4, 1'b1, 1'b1));
    wait_idle();
    phy_val = 16'hFFFE;
    host_write(CTRL, cmd_word(5'h00, 5'h1F, 3'd5, 1'b0, 1'b1));
    wait_idle();
    host_read(DATA, rd); check(rd == 32'hFFFE, "R6 read range 5", rd, 32'hFFFE);
    phy_val = 16'h0000;
    host_write(CTRL, cmd_word(5'h1B, 5'h02, 3'd7, 1'b0, 1'b1));
    wait_idle();
    host_read(DATA, rd); check(rd == 32'h0000, "R6 read range 7", rd, 32'h0);
    host_read(CTRL, rd);
    check(rd == {16'h0, 5'h1B, 5'h02, 1'b0, 3'd7, 1'b0, 1'b0}, "R1 ctrl readback idle",
          rd, {16'h0, 5'h1B, 5'h02, 6'b011100});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule